// File: doc/BRIEF.md
# Programmable Clock Gear Controller

This block slows a chip's system timing down from a fast input clock so that logic can run at a reduced rate and use less power. It never gates or switches a real clock. Instead it produces two clock-enable strobes, each one input-clock cycle wide. The gear strobe fires once every 1, 2, 4, 8 or 16 input cycles. The system strobe fires on every second gear strobe, so the system rate is always half the gear rate.

Software picks the gear by writing a byte register through a simple write port. A newly written gear is held as pending. It becomes active only when the divide counter of the gear in force wraps. Because of this, no strobe spacing is ever shortened. Until the switch happens, a busy flag stays high, and the write that follows may still see the old rate.

Top module: `gear_clock_ctrl`

## Requirements
- R1: After the synchronous active-high reset is released, the gear code reads back as 3'b100 (divide by 16) and busy is 0. Counting the first cycle after release as cycle 1, the first gear strobe is high in cycle 16 and the first system strobe in cycle 32.
- R2: Gear code c in 0..4 (000, 001, 010, 011, 100) makes the gear strobe fire every 2^c input cycles, that is 1, 2, 4, 8 or 16. Apart from divide-by-1, each strobe is high for exactly one cycle.
- R3: The system strobe is high only together with the gear strobe, and only on every second gear strobe. With divide-by-1 the gear strobe stays high and the system strobe is high every second cycle.
- R4: A write takes wdata[2:0] as the code and ignores wdata[7:3]. rdata is {5'b00000, last accepted code}, with bits [7:3] always zero.
- R5: A write with a reserved code (3'b101, 3'b110, 3'b111) changes nothing: busy, rdata and the strobe rate all stay as they were.
- R6: busy is high from the cycle after a valid write. It falls after the first clock edge at which the counter of the current gear wraps. The new ratio counts from that edge, so every strobe spacing equals either the old ratio or the new one.
- R7: A valid write while busy replaces the pending code. Only the last code written takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 8 | Write data; bits [2:0] carry the gear code |
| rdata | output | 8 | Read data: {5'b0, last accepted gear code} |
| busy | output | 1 | A gear change is pending |
| gear_en | output | 1 | Gear-rate clock enable |
| sys_en | output | 1 | System-rate clock enable (half the gear rate) |

## Verification
All four outputs are decoded combinationally from registered state. A write sampled at a rising edge therefore shows up in rdata and busy during the very next cycle. A pending gear affects the strobes only from the cycle after the wrap edge that applies it. The bench changes inputs and reads outputs at the falling edge. Before each step it compares the outputs against a cycle model held in bench variables, so every result is checked exactly in the cycle it becomes due. Separate directed counts check the reset timing at cycles 16 and 32, the divide-by-1 pattern, and the replacement of a pending code.

// File: rtl/gear_pkg.sv
package gear_pkg;
    localparam int REG_W      = 8;
    localparam int CODE_W     = 3;
    localparam int NUM_GEARS  = 5;
    localparam int CNT_W      = NUM_GEARS - 1;
    localparam logic [CODE_W-1:0] RESET_CODE = 3'd4;

    typedef logic [CODE_W-1:0] gear_code_t;
endpackage

// File: rtl/gear_reg.sv
module gear_reg
    import gear_pkg::*;
#(
    parameter int REG_W      = gear_pkg::REG_W,
    parameter int CODE_W     = gear_pkg::CODE_W,
    parameter int NUM_GEARS  = gear_pkg::NUM_GEARS,
    parameter logic [CODE_W-1:0] RESET_CODE = gear_pkg::RESET_CODE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wdata,
    input  logic              apply,
    output logic [CODE_W-1:0] pend_code,
    output logic              busy,
    output logic [REG_W-1:0]  rdata
);
    localparam logic [CODE_W-1:0] LAST_CODE = CODE_W'(NUM_GEARS - 1);

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              busy;
    } reg_state_t;

    reg_state_t state_d, state_q;
    logic [CODE_W-1:0] wr_code;

    assign wr_code = wdata[CODE_W-1:0];

    always_comb begin
        state_d = state_q;
        if (apply) begin
            state_d.busy = 1'b0;
        end
        if (wr_en && (wr_code <= LAST_CODE)) begin
            state_d.code = wr_code;
            state_d.busy = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.code <= RESET_CODE;
            state_q.busy <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pend_code = state_q.code;
    assign busy      = state_q.busy;
    assign rdata     = {{(REG_W-CODE_W){1'b0}}, state_q.code};
endmodule

// File: rtl/gear_div.sv
module gear_div
    import gear_pkg::*;
#(
    parameter int CODE_W = gear_pkg::CODE_W,
    parameter int CNT_W  = gear_pkg::CNT_W,
    parameter logic [CODE_W-1:0] RESET_CODE = gear_pkg::RESET_CODE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] pend_code,
    input  logic              pending,
    output logic              gear_en,
    output logic              sys_en,
    output logic              apply
);
    typedef struct packed {
        logic [CODE_W-1:0] gear;
        logic [CNT_W-1:0]  cnt;
        logic              phase;
    } div_state_t;

    div_state_t state_d, state_q;
    logic [CNT_W-1:0] limit;
    logic             wrap;

    // terminal count = 2^gear - 1: bit i set when gear exceeds i
    for (genvar i = 0; i < CNT_W; i++) begin : g_limit
        assign limit[i] = (state_q.gear > CODE_W'(i));
    end

    assign wrap    = (state_q.cnt == limit);
    assign gear_en = wrap;
    assign sys_en  = wrap & state_q.phase;
    assign apply   = wrap & pending;

    always_comb begin
        state_d = state_q;
        if (wrap) begin
            state_d.cnt   = '0;
            state_d.phase = ~state_q.phase;
            if (pending) begin
                state_d.gear = pend_code;
            end
        end else begin
            state_d.cnt = state_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.gear  <= RESET_CODE;
            state_q.cnt   <= '0;
            state_q.phase <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/gear_clock_ctrl.sv
module gear_clock_ctrl
    import gear_pkg::*;
#(
    parameter int REG_W     = gear_pkg::REG_W,
    parameter int CODE_W    = gear_pkg::CODE_W,
    parameter int NUM_GEARS = gear_pkg::NUM_GEARS,
    parameter logic [CODE_W-1:0] RESET_CODE = gear_pkg::RESET_CODE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic             busy,
    output logic             gear_en,
    output logic             sys_en
);
    localparam int CNT_W = NUM_GEARS - 1;

    logic [CODE_W-1:0] pend_code;
    logic              apply;

    gear_reg #(
        .REG_W(REG_W), .CODE_W(CODE_W), .NUM_GEARS(NUM_GEARS), .RESET_CODE(RESET_CODE)
    ) u_reg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wdata(wdata), .apply(apply),
        .pend_code(pend_code), .busy(busy), .rdata(rdata)
    );

    gear_div #(
        .CODE_W(CODE_W), .CNT_W(CNT_W), .RESET_CODE(RESET_CODE)
    ) u_div (
        .clk(clk), .rst(rst), .pend_code(pend_code), .pending(busy),
        .gear_en(gear_en), .sys_en(sys_en), .apply(apply)
    );
endmodule

// File: rtl/gear_clock_ctrl_chk.sv
module gear_clock_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic       busy,
    input logic       gear_en,
    input logic       sys_en
);
    logic [4:0] gap_q;
    logic [5:0] span;

    always_ff @(posedge clk) begin
        if (rst)          gap_q <= '0;
        else if (gear_en) gap_q <= '0;
        else if (gap_q != 5'd31) gap_q <= gap_q + 5'd1;
    end

    assign span = {1'b0, gap_q} + 6'd1;

    assert_spacing_R2: assert property (@(posedge clk) disable iff (rst)
        gear_en |-> ($countones(span) == 1 && span <= 6'd16));

    assert_sys_in_gear_R3: assert property (@(posedge clk) disable iff (rst)
        sys_en |-> gear_en);

    assert_sys_alternate_R3: assert property (@(posedge clk) disable iff (rst)
        sys_en |=> !sys_en);

    assert_upper_zero_R4: assert property (@(posedge clk) disable iff (rst)
        rdata[7:3] == 5'd0);

    assert_reserved_ignored_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wdata[2:0] > 3'd4 && !busy) |=> (!busy && $stable(rdata)));

    assert_write_busy_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wdata[2:0] <= 3'd4) |=> busy);

    assert_busy_release_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(gear_en));
endmodule

bind gear_clock_ctrl gear_clock_ctrl_chk u_chk (.*);

// File: tb/gear_clock_ctrl_test.sv
module gear_clock_ctrl_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       busy, gear_en, sys_en;

    always #5 clk = ~clk;

    gear_clock_ctrl uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .busy(busy), .gear_en(gear_en), .sys_en(sys_en)
    );

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // bench cycle model built from the requirements
    int m_gear = 4, m_pend = 4, m_cnt = 0;
    bit m_busy = 0, m_ph = 0;
    int cyc = 0, first_g = 0, first_s = 0, last_g = 0;

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic bit exp_gear();
        return m_cnt == ((1 << m_gear) - 1);
    endfunction

    function automatic bit exp_sys();
        return exp_gear() && m_ph;
    endfunction

    function automatic bit is_pow2_le16(int v);
        return (v == 1 || v == 2 || v == 4 || v == 8 || v == 16);
    endfunction

    // called at a falling edge: compare, drive, advance model, wait one cycle
    task automatic step(bit w, logic [7:0] d);
        bit g;
        cyc++;
        g = exp_gear();
        check(gear_en == g, "R2 gear_en", gear_en, g);
        check(sys_en == exp_sys(), "R3 sys_en", sys_en, exp_sys());
        check(rdata == 8'(m_pend), "R4 rdata", rdata, m_pend);
        check(busy == m_busy, "R6 busy", busy, m_busy);
        if (gear_en) begin
            if (first_g == 0) first_g = cyc;
            if (last_g != 0) check(is_pow2_le16(cyc - last_g), "R2 spacing", cyc - last_g, 16);
            last_g = cyc;
        end
        if (sys_en && first_s == 0) first_s = cyc;
        wr_en = w;
        wdata = d;
        if (g) begin
            m_ph = ~m_ph;
            m_cnt = 0;
            if (m_busy) begin
                m_gear = m_pend;
                m_busy = 0;
            end
        end else begin
            m_cnt++;
        end
        if (w && d[2:0] <= 3'd4) begin
            m_pend = int'(d[2:0]);
            m_busy = 1;
        end
        @(negedge clk);
    endtask

    task automatic settle();
        for (int i = 0; i < 100 && m_busy; i++) step(0, 8'h00);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int gc, sc;
        void'($urandom(32'd2024));
        rst = 1'b1;
        wr_en = 1'b0;
        wdata = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check(rdata == 8'h04, "R1 reset code", rdata, 4);
        check(busy == 1'b0, "R1 reset busy", busy, 0);
        for (int i = 0; i < 40; i++) step(0, 8'h00);
        check(first_g == 16, "R1 first gear_en", first_g, 16);
        check(first_s == 32, "R1 first sys_en", first_s, 32);

        // R4/R3: code 0 with upper bits set, then divide-by-1 pattern
        step(1, 8'hF8);
        check(busy == 1'b1, "R6 busy after write", busy, 1);
        check(rdata == 8'h00, "R4 upper bits ignored", rdata, 0);
        settle();
        step(0, 8'h00);
        gc = 0; sc = 0;
        for (int i = 0; i < 10; i++) begin
            if (gear_en) gc++;
            if (sys_en) sc++;
            step(0, 8'h00);
        end
        check(gc == 10, "R3 div1 gear_en count", gc, 10);
        check(sc == 5, "R3 div1 sys_en count", sc, 5);

        // R5: reserved code ignored
        step(1, 8'hAF);
        check(busy == 1'b0, "R5 reserved busy", busy, 0);
        check(rdata == 8'h00, "R5 reserved rdata", rdata, 0);
        for (int i = 0; i < 6; i++) step(0, 8'h00);

        // R7: pending code replaced while busy
        step(1, 8'h04);
        settle();
        step(1, 8'h03);
        step(1, 8'h01);
        check(rdata == 8'h01, "R7 replaced pending", rdata, 1);
        settle();
        check(rdata == 8'h01 && busy == 1'b0, "R7 final code", rdata, 1);
        for (int i = 0; i < 12; i++) step(0, 8'h00);

        // R6 busy across every gear, then random writes
        for (int c = 0; c < 5; c++) begin
            step(1, 8'(c) | 8'h50);
            settle();
            for (int i = 0; i < 40; i++) step(0, 8'h00);
        end
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] d;
            bit w;
            w = ($urandom % 24) == 0;
            d = 8'($urandom);
            step(w, d);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule